// File: doc/BRIEF.md
# Command Ring Consumer

This block drains 32-bit command words that a producer places in a circular buffer held in shared memory. The buffer is described by four byte offsets: a lower bound, an upper bound, the producer's write pointer and the consumer's read pointer. Software presents these values and pulses a configure strobe. The block checks the descriptor and, if it is accepted, takes over the read pointer. A sync pulse starts a processing pass. During the pass the block fetches an opcode, then that opcode's arguments, and hands the decoded operation to a drawing engine over a valid/ready port. It repeats this until the ring is empty.

Screen-update, fill, copy and cursor-shape commands are executed. A cursor-shape command also streams its mask words and image words out of a payload port. Some opcodes are recognised but not executed. Their argument words are read and discarded, so the read pointer stays in step with the producer. An opcode of zero, or any opcode the block does not recognise, ends the pass.

The drawing itself is outside this block. So is arbitration for the memory: the block issues one read at a time on a request/acknowledge port, and data arrives with the acknowledge.

Top module: `cmdring_consumer`

## Requirements
- R1: `empty_o` is 1 when `enable_i` is 0, when no descriptor has been accepted, or when `ring_next_i` equals `stop_o`. A sync pulse while `empty_o` is 1 leaves `busy_o` and `mem_req_o` at 0 and `stop_o` unchanged.
- R2: Each acknowledged read uses `mem_addr_o` = `stop_o`. On that read, `stop_o` advances by 4. When the advanced value is greater than or equal to the upper bound, `stop_o` becomes the lower bound instead.
- R3: A configure pulse clears `cfg_ok_o` if any of the four offsets has either of bits [1:0] set.
- R4: A configure pulse clears `cfg_ok_o` if the upper bound exceeds `FIFO_BYTES` (default 0x10000), or if upper minus lower is below `MIN_SPAN` (default 10240). A span of exactly `MIN_SPAN` and an upper bound of exactly `FIFO_BYTES` are both accepted.
- R5: A configure pulse clears `cfg_ok_o` if the lower bound is below `HDR_BYTES` (default 16). An accepted descriptor sets `cfg_ok_o` and loads `stop_o` from `ring_stop_i` one cycle after the pulse.
- R6: Opcodes 1 and 25 read 4 arguments (x, y, w, h) and are dispatched with `op_kind_o` = 0.
- R7: Opcode 2 reads 5 arguments (colour, x, y, w, h) and is dispatched with kind 1. Opcode 3 reads 6 arguments (src x, src y, dst x, dst y, w, h) and is dispatched with kind 2. Argument n sits in `op_args_o[32n+31:32n]`, and unused slots read 0.
- R8: Opcode 19 reads 6 arguments (id, hot x, hot y, width, height, bpp) and is dispatched with kind 3. After `op_ready_i` it streams ((width+31)>>5)*height mask words with `pay_image_o`=0, then ((width*bpp+31)>>5)*height image words with `pay_image_o`=1.
- R9: Opcodes 13, 14 and 28 are skipped without dispatch by reading and discarding 6, 7 and 12 words respectively.
- R10: Opcode 24 reads one length word L, then discards 7+(L>>2) further words without dispatch.
- R11: Opcode 0, or any opcode not listed in R6 to R10, is consumed (`stop_o` advances by 4) and ends the pass. The words after it stay in the ring.
- R12: A sync pulse with `empty_o`=0 raises `busy_o` on the next cycle. `busy_o` stays high until the ring is found empty after a command, or until a pass-ending opcode is consumed.
- R13: While `op_valid_o` is 1 and `op_ready_i` is 0, `op_valid_o`, `op_kind_o` and `op_args_o` hold. No memory read is requested while an operation is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Device enable; when 0 the ring reads as empty |
| cfg_done_i | input | 1 | Configure strobe: check and capture the descriptor |
| sync_i | input | 1 | Starts a processing pass |
| ring_min_i | input | 32 | Lower bound byte offset |
| ring_max_i | input | 32 | Upper bound byte offset |
| ring_next_i | input | 32 | Producer write pointer (live) |
| ring_stop_i | input | 32 | Initial consumer read pointer |
| cfg_ok_o | output | 1 | Last descriptor was accepted |
| stop_o | output | 32 | Consumer read pointer |
| empty_o | output | 1 | Ring has nothing to consume |
| busy_o | output | 1 | A pass is in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Byte offset of the read |
| mem_ack_i | input | 1 | Read accepted; data valid this cycle |
| mem_data_i | input | 32 | Read data |
| op_valid_o | output | 1 | Decoded operation offered |
| op_kind_o | output | 2 | 0 update, 1 fill, 2 copy, 3 cursor shape |
| op_args_o | output | 192 | Six 32-bit argument slots, slot 0 lowest |
| op_ready_i | input | 1 | Drawing engine takes the operation |
| pay_valid_o | output | 1 | Cursor payload word present |
| pay_image_o | output | 1 | Payload word is image (1) or mask (0) |
| pay_data_o | output | 32 | Cursor payload word |

## Verification
The assertions take for granted that the configure strobe is never pulsed during a pass. They also take for granted that `mem_data_i` is meaningful only in a cycle where the acknowledge answers a request. The pointer-step property excludes cycles with a configure pulse for the same reason. The stimulus keeps to these rules: it reconfigures only while `busy_o` is low, and it acknowledges only requests that are raised. It also stalls the acknowledge one cycle in four and holds off ready for two cycles, so that the hold rules are actually exercised.

// File: rtl/cmdring_pkg.sv
// Shared types for the command ring consumer: operation kinds, opcode
// classes, sequencer states and the opcode classification function.
// Assumes 32-bit command words.
package cmdring_pkg;

    localparam int WORD_W    = 32;
    localparam int ARG_SLOTS = 6;
    localparam int NARG_W    = 4;

    typedef enum logic [1:0] {
        OPK_UPDATE = 2'd0,
        OPK_FILL   = 2'd1,
        OPK_COPY   = 2'd2,
        OPK_CURSOR = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        CLS_END   = 2'd0,
        CLS_EXEC  = 2'd1,
        CLS_SKIP  = 2'd2,
        CLS_GLYPH = 2'd3
    } op_class_e;

    typedef struct packed {
        op_class_e          cls;
        op_kind_e           kind;
        logic [NARG_W-1:0]  nargs;
    } op_info_t;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_CHECK  = 4'd1,
        ST_OPCODE = 4'd2,
        ST_ARGS   = 4'd3,
        ST_ISSUE  = 4'd4,
        ST_MASK   = 4'd5,
        ST_IMAGE  = 4'd6,
        ST_GLEN   = 4'd7,
        ST_SKIP   = 4'd8
    } seq_state_e;

    // Map an opcode word to its handling class and fixed argument count.
    function automatic op_info_t classify(input logic [WORD_W-1:0] word);
        op_info_t r;
        r = '{cls: CLS_END, kind: OPK_UPDATE, nargs: '0};
        case (word)
            32'd1, 32'd25: r = '{cls: CLS_EXEC,  kind: OPK_UPDATE, nargs: 4'd4};
            32'd2:         r = '{cls: CLS_EXEC,  kind: OPK_FILL,   nargs: 4'd5};
            32'd3:         r = '{cls: CLS_EXEC,  kind: OPK_COPY,   nargs: 4'd6};
            32'd19:        r = '{cls: CLS_EXEC,  kind: OPK_CURSOR, nargs: 4'd6};
            32'd13:        r = '{cls: CLS_SKIP,  kind: OPK_UPDATE, nargs: 4'd6};
            32'd14:        r = '{cls: CLS_SKIP,  kind: OPK_UPDATE, nargs: 4'd7};
            32'd28:        r = '{cls: CLS_SKIP,  kind: OPK_UPDATE, nargs: 4'd12};
            32'd24:        r = '{cls: CLS_GLYPH, kind: OPK_UPDATE, nargs: 4'd0};
            default:       r = '{cls: CLS_END,   kind: OPK_UPDATE, nargs: 4'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmdring_desc.sv
// Ring descriptor holder: checks a descriptor on the configure strobe,
// keeps the bounds and the consumer pointer, and reports emptiness.
// Assumes the strobe is not pulsed while reads are advancing the pointer.
module cmdring_desc #(
    parameter logic [31:0] FIFO_BYTES = 32'h0001_0000,
    parameter logic [31:0] MIN_SPAN   = 32'd10240,
    parameter logic [31:0] HDR_BYTES  = 32'd16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable_i,
    input  logic        cfg_done_i,
    input  logic [31:0] min_i,
    input  logic [31:0] max_i,
    input  logic [31:0] next_i,
    input  logic [31:0] stop_i,
    input  logic        advance_i,
    output logic        cfg_ok_o,
    output logic [31:0] stop_o,
    output logic        empty_o
);
    logic        aligned, in_range, span_ok, above_hdr, accept;
    logic [32:0] span_end;
    logic [31:0] min_q, max_q, stop_q, stop_inc, stop_nxt;
    logic        ok_q;

    // Descriptor acceptance rules.
    always_comb begin
        aligned   = ((min_i | max_i | next_i | stop_i) & 32'h3) == 32'h0;
        in_range  = max_i <= FIFO_BYTES;
        span_end  = {1'b0, min_i} + {1'b0, MIN_SPAN};
        span_ok   = {1'b0, max_i} >= span_end;
        above_hdr = min_i >= HDR_BYTES;
        accept    = aligned && in_range && span_ok && above_hdr;
    end

    // Pointer step with wrap back to the lower bound.
    always_comb begin
        stop_inc = stop_q + 32'd4;
        stop_nxt = (stop_inc >= max_q) ? min_q : stop_inc;
    end

    // Capture descriptor on configure, otherwise advance on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q   <= 1'b0;
            min_q  <= '0;
            max_q  <= '0;
            stop_q <= '0;
        end else if (cfg_done_i) begin
            ok_q <= accept;
            if (accept) begin
                min_q  <= min_i;
                max_q  <= max_i;
                stop_q <= stop_i;
            end
        end else if (advance_i) begin
            stop_q <= stop_nxt;
        end
    end

    assign cfg_ok_o = ok_q;
    assign stop_o   = stop_q;
    assign empty_o  = !enable_i || !ok_q || (next_i == stop_q);

endmodule

// File: rtl/cmdring_argbuf.sv
// Argument collector: writes successive words into numbered slots and
// exposes all slots flat. Assumes clear_i precedes each command.
module cmdring_argbuf #(
    parameter int SLOTS = 6,
    parameter int W     = 32,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               load_i,
    input  logic [W-1:0]       data_i,
    output logic [IDX_W-1:0]   count_o,
    output logic [SLOTS*W-1:0] args_o
);
    logic [IDX_W-1:0] idx_q;

    // Slot index: reset on clear, step on each load.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) idx_q <= '0;
        else if (load_i)       idx_q <= idx_q + 1'b1;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [W-1:0] slot_q;
        // One argument slot, zeroed on clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)                        slot_q <= '0;
            else if (load_i && idx_q == IDX_W'(g))        slot_q <= data_i;
        end
        assign args_o[g*W +: W] = slot_q;
    end

    assign count_o = idx_q;

endmodule

// File: rtl/cmdring_cursz.sv
// Cursor payload sizing: mask and image word counts from the cursor
// width, height and bits per pixel. Arithmetic wraps at 32 bits.
module cmdring_cursz #(
    parameter int W = 32
) (
    input  logic [W-1:0] width_i,
    input  logic [W-1:0] height_i,
    input  logic [W-1:0] bpp_i,
    output logic [W-1:0] mask_words_o,
    output logic [W-1:0] image_words_o
);
    logic [W-1:0] mask_row, image_bits, image_row;

    // Words per row rounded up to 32 bits, times rows.
    always_comb begin
        mask_row      = (width_i + W'(31)) >> 5;
        image_bits    = width_i * bpp_i;
        image_row     = (image_bits + W'(31)) >> 5;
        mask_words_o  = mask_row * height_i;
        image_words_o = image_row * height_i;
    end

endmodule

// File: rtl/cmdring_consumer.sv
// Command ring consumer top: on sync, drains opcodes and arguments from a
// ring in shared memory, dispatches executable operations, streams cursor
// payload and discards arguments of recognised but unexecuted opcodes.
// Assumes one outstanding read, data valid with the acknowledge, and no
// configure strobe while busy.
module cmdring_consumer
    import cmdring_pkg::*;
#(
    parameter logic [31:0] FIFO_BYTES = 32'h0001_0000,
    parameter logic [31:0] MIN_SPAN   = 32'd10240,
    parameter logic [31:0] HDR_BYTES  = 32'd16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable_i,
    input  logic                        cfg_done_i,
    input  logic                        sync_i,
    input  logic [31:0]                 ring_min_i,
    input  logic [31:0]                 ring_max_i,
    input  logic [31:0]                 ring_next_i,
    input  logic [31:0]                 ring_stop_i,
    output logic                        cfg_ok_o,
    output logic [31:0]                 stop_o,
    output logic                        empty_o,
    output logic                        busy_o,
    output logic                        mem_req_o,
    output logic [31:0]                 mem_addr_o,
    input  logic                        mem_ack_i,
    input  logic [31:0]                 mem_data_i,
    output logic                        op_valid_o,
    output logic [1:0]                  op_kind_o,
    output logic [ARG_SLOTS*WORD_W-1:0] op_args_o,
    input  logic                        op_ready_i,
    output logic                        pay_valid_o,
    output logic                        pay_image_o,
    output logic [31:0]                 pay_data_o
);
    localparam int ARGS_W = ARG_SLOTS * WORD_W;

    seq_state_e          state_q, state_d;
    op_info_t            info_q, info_w;
    logic [WORD_W-1:0]   cnt_q, cnt_d;
    logic [NARG_W-1:0]   arg_cnt;
    logic [WORD_W-1:0]   mask_words, image_words;
    logic                fetch, last_arg, empty_w;
    logic [ARGS_W-1:0]   args_w;

    assign fetch    = mem_req_o && mem_ack_i;
    assign info_w   = classify(mem_data_i);
    assign last_arg = (arg_cnt + 1'b1) == info_q.nargs;

    cmdring_desc #(
        .FIFO_BYTES (FIFO_BYTES),
        .MIN_SPAN   (MIN_SPAN),
        .HDR_BYTES  (HDR_BYTES)
    ) u_desc (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .cfg_done_i (cfg_done_i),
        .min_i      (ring_min_i),
        .max_i      (ring_max_i),
        .next_i     (ring_next_i),
        .stop_i     (ring_stop_i),
        .advance_i  (fetch),
        .cfg_ok_o   (cfg_ok_o),
        .stop_o     (stop_o),
        .empty_o    (empty_w)
    );

    cmdring_argbuf #(
        .SLOTS   (ARG_SLOTS),
        .W       (WORD_W),
        .IDX_W   (NARG_W)
    ) u_args (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == ST_OPCODE && fetch),
        .load_i  (state_q == ST_ARGS && fetch),
        .data_i  (mem_data_i),
        .count_o (arg_cnt),
        .args_o  (args_w)
    );

    cmdring_cursz #(
        .W             (WORD_W)
    ) u_cursz (
        .width_i       (args_w[3*WORD_W +: WORD_W]),
        .height_i      (args_w[4*WORD_W +: WORD_W]),
        .bpp_i         (args_w[5*WORD_W +: WORD_W]),
        .mask_words_o  (mask_words),
        .image_words_o (image_words)
    );

    // Sequencer next state and word counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_IDLE:   if (sync_i && !empty_w) state_d = ST_OPCODE;
            ST_CHECK:  state_d = empty_w ? ST_IDLE : ST_OPCODE;
            ST_OPCODE: if (fetch) begin
                case (info_w.cls)
                    CLS_EXEC:  state_d = ST_ARGS;
                    CLS_SKIP:  begin
                        state_d = ST_SKIP;
                        cnt_d   = WORD_W'(info_w.nargs);
                    end
                    CLS_GLYPH: state_d = ST_GLEN;
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_ARGS:   if (fetch && last_arg) state_d = ST_ISSUE;
            ST_ISSUE:  if (op_ready_i) begin
                if (info_q.kind != OPK_CURSOR) begin
                    state_d = ST_CHECK;
                end else if (mask_words != '0) begin
                    state_d = ST_MASK;
                    cnt_d   = mask_words;
                end else if (image_words != '0) begin
                    state_d = ST_IMAGE;
                    cnt_d   = image_words;
                end else begin
                    state_d = ST_CHECK;
                end
            end
            ST_MASK:   if (fetch) begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == WORD_W'(1)) begin
                    if (image_words != '0) begin
                        state_d = ST_IMAGE;
                        cnt_d   = image_words;
                    end else begin
                        state_d = ST_CHECK;
                    end
                end
            end
            ST_GLEN:   if (fetch) begin
                state_d = ST_SKIP;
                cnt_d   = WORD_W'(7) + (mem_data_i >> 2);
            end
            ST_IMAGE, ST_SKIP: if (fetch) begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == WORD_W'(1)) state_d = ST_CHECK;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers; opcode class captured with the opcode word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            info_q  <= '{cls: CLS_END, kind: OPK_UPDATE, nargs: '0};
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_OPCODE && fetch) info_q <= info_w;
        end
    end

    assign mem_req_o   = (state_q == ST_OPCODE) || (state_q == ST_ARGS) ||
                         (state_q == ST_MASK)   || (state_q == ST_IMAGE) ||
                         (state_q == ST_GLEN)   || (state_q == ST_SKIP);
    assign mem_addr_o  = stop_o;
    assign empty_o     = empty_w;
    assign busy_o      = state_q != ST_IDLE;
    assign op_valid_o  = state_q == ST_ISSUE;
    assign op_kind_o   = info_q.kind;
    assign op_args_o   = args_w;
    assign pay_valid_o = ((state_q == ST_MASK) || (state_q == ST_IMAGE)) && fetch;
    assign pay_image_o = state_q == ST_IMAGE;
    assign pay_data_o  = mem_data_i;

endmodule

// File: rtl/cmdring_consumer_chk.sv
// Property checker for the command ring consumer, bound to its top.
// Assumes the configure strobe is only pulsed between passes.
module cmdring_consumer_chk #(
    parameter int ARGS_W = 192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_done_i,
    input logic              cfg_ok_o,
    input logic              empty_o,
    input logic              busy_o,
    input logic              mem_req_o,
    input logic              mem_ack_i,
    input logic [31:0]       stop_o,
    input logic              op_valid_o,
    input logic              op_ready_i,
    input logic [1:0]        op_kind_o,
    input logic [ARGS_W-1:0] op_args_o,
    input logic              pay_valid_o
);
    AST_EMPTY_UNCFG: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok_o |-> empty_o); // R1
    AST_STOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ack_i && !cfg_done_i |=>
            (stop_o == $past(stop_o) + 32'd4) || (stop_o < $past(stop_o))); // R2
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && mem_ack_i) && !cfg_done_i |=> $stable(stop_o)); // R2
    AST_STOP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok_o |-> stop_o[1:0] == 2'b00); // R3
    AST_PAY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid_o |-> mem_req_o && mem_ack_i); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !op_valid_o && !pay_valid_o); // R12
    AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_o && !op_ready_i |=>
            op_valid_o && $stable(op_kind_o) && $stable(op_args_o)); // R13
    AST_OP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_o |-> !mem_req_o); // R13
endmodule

bind cmdring_consumer cmdring_consumer_chk #(
    .ARGS_W      (cmdring_pkg::ARG_SLOTS * cmdring_pkg::WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_done_i  (cfg_done_i),
    .cfg_ok_o    (cfg_ok_o),
    .empty_o     (empty_o),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_ack_i   (mem_ack_i),
    .stop_o      (stop_o),
    .op_valid_o  (op_valid_o),
    .op_ready_i  (op_ready_i),
    .op_kind_o   (op_kind_o),
    .op_args_o   (op_args_o),
    .pay_valid_o (pay_valid_o)
);

// File: tb/cmdring_consumer_bench.sv
module cmdring_consumer_bench;
    localparam logic [31:0] RMIN = 32'd16;
    localparam logic [31:0] RMAX = 32'd16 + 32'd10240;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b1;
    logic         cfg_done = 1'b0;
    logic         sync = 1'b0;
    logic [31:0]  r_min = '0, r_max = '0, r_next = '0, r_stop = '0;
    logic         cfg_ok, empty, busy, mem_req, mem_ack, op_valid, op_ready = 1'b0;
    logic [31:0]  stop, mem_addr, mem_data, pay_data;
    logic [1:0]   op_kind;
    logic [191:0] op_args, first_args;
    logic         pay_valid, pay_image;
    logic [1:0]   stall_cnt = '0;
    int           hold = 0;
    int           n_checks = 0, n_fail = 0;
    logic [31:0]  wptr = '0;
    bit           done = 1'b0;

    logic [31:0]  mem [0:4095];
    logic [1:0]   k_q[$];
    logic [191:0] a_q[$];
    logic [31:0]  p_q[$];
    bit           pi_q[$];

    always #10 clk = ~clk;

    cmdring_consumer u_cmdring_consumer (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .cfg_done_i(cfg_done),
        .sync_i(sync), .ring_min_i(r_min), .ring_max_i(r_max),
        .ring_next_i(r_next), .ring_stop_i(r_stop), .cfg_ok_o(cfg_ok),
        .stop_o(stop), .empty_o(empty), .busy_o(busy), .mem_req_o(mem_req),
        .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_data_i(mem_data),
        .op_valid_o(op_valid), .op_kind_o(op_kind), .op_args_o(op_args),
        .op_ready_i(op_ready), .pay_valid_o(pay_valid),
        .pay_image_o(pay_image), .pay_data_o(pay_data)
    );

    // Memory model: acknowledge stalls one cycle in four.
    always @(posedge clk) stall_cnt <= stall_cnt + 2'd1;
    assign mem_ack  = mem_req && (stall_cnt != 2'd3);
    assign mem_data = mem[mem_addr[13:2]];

    // Drawing engine: takes each operation after two cycles of hold.
    always @(negedge clk) begin
        if (op_valid && !op_ready) begin
            if (hold == 0) first_args = op_args;
            if (hold == 2) begin
                check(op_args == first_args, "R13", "args held", op_args[63:0], first_args[63:0]);
                k_q.push_back(op_kind);
                a_q.push_back(op_args);
                op_ready <= 1'b1;
                hold = 0;
            end else begin
                hold = hold + 1;
            end
        end else begin
            op_ready <= 1'b0;
        end
        if (pay_valid) begin
            p_q.push_back(pay_data);
            pi_q.push_back(pay_image);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [191:0] pk(input logic [31:0] a0, a1, a2, a3, a4, a5);
        return {a5, a4, a3, a2, a1, a0};
    endfunction

    task automatic put(input logic [31:0] w);
        mem[wptr[13:2]] = w;
        wptr = wptr + 32'd4;
        if (wptr >= r_max) wptr = r_min;
    endtask

    task automatic publish();
        @(negedge clk);
        r_next = wptr;
    endtask

    task automatic cfg(input logic [31:0] mn, mx, st);
        @(negedge clk);
        r_min = mn; r_max = mx; r_stop = st; r_next = st; cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    task automatic clear_q();
        k_q.delete(); a_q.delete(); p_q.delete(); pi_q.delete();
    endtask

    task automatic run_pass(input bit expect_busy);
        clear_q();
        @(negedge clk); sync = 1'b1;
        @(negedge clk); sync = 1'b0;
        if (expect_busy) check(busy == 1'b1, "R12", "busy after sync", 64'(busy), 64'd1);
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        check(busy == 1'b0, "R12", "pass ends", 64'(busy), 64'd0);
    endtask

    task automatic t_reset();
        check(cfg_ok == 1'b0, "R5", "reset cfg_ok", 64'(cfg_ok), 64'd0);
        check(empty == 1'b1, "R1", "reset empty", 64'(empty), 64'd1);
        check(busy == 1'b0 && mem_req == 1'b0 && op_valid == 1'b0, "R12", "reset quiet",
              64'({busy, mem_req, op_valid}), 64'd0);
    endtask

    task automatic t_config();
        cfg(RMIN, RMAX, 32'd22);
        check(cfg_ok == 1'b0, "R3", "misaligned stop", 64'(cfg_ok), 64'd0);
        cfg(RMIN, RMAX, RMIN);
        check(cfg_ok == 1'b1, "R4", "span exactly minimum", 64'(cfg_ok), 64'd1);
        cfg(32'd16, 32'h0001_0004, 32'd16);
        check(cfg_ok == 1'b0, "R4", "max above fifo size", 64'(cfg_ok), 64'd0);
        cfg(32'd16, 32'h0001_0000, 32'd16);
        check(cfg_ok == 1'b1, "R4", "max equal fifo size", 64'(cfg_ok), 64'd1);
        cfg(RMIN, RMAX - 32'd4, RMIN);
        check(cfg_ok == 1'b0, "R4", "span short", 64'(cfg_ok), 64'd0);
        cfg(32'd12, 32'd12 + 32'd10240, 32'd12);
        check(cfg_ok == 1'b0, "R5", "min inside header", 64'(cfg_ok), 64'd0);
        cfg(RMIN, RMAX, 32'd40);
        check(cfg_ok == 1'b1 && stop == 32'd40, "R5", "stop loaded", 64'(stop), 64'd40);
        check(empty == 1'b1, "R1", "next equals stop", 64'(empty), 64'd1);
        wptr = 32'd40;
    endtask

    task automatic t_empty_sync();
        logic [31:0] s0;
        s0 = stop;
        @(negedge clk); sync = 1'b1;
        @(negedge clk); sync = 1'b0;
        check(busy == 1'b0 && mem_req == 1'b0, "R1", "sync on empty", 64'({busy, mem_req}), 64'd0);
        check(stop == s0, "R1", "stop kept", 64'(stop), 64'(s0));
    endtask

    task automatic t_update();
        put(1); put(10); put(20); put(30); put(40);
        put(25); put(5); put(6); put(7); put(8);
        publish();
        run_pass(1'b1);
        check(k_q.size() == 2, "R6", "update count", 64'(k_q.size()), 64'd2);
        if (k_q.size() == 2) begin
            check(k_q[0] == 2'd0 && a_q[0] == pk(10, 20, 30, 40, 0, 0), "R6", "update args",
                  a_q[0][63:0], 64'h14_0000000a);
            check(k_q[1] == 2'd0 && a_q[1] == pk(5, 6, 7, 8, 0, 0), "R6", "verbose update args",
                  a_q[1][63:0], 64'h6_00000005);
        end
        check(stop == wptr && empty == 1'b1, "R2", "stop after update", 64'(stop), 64'(wptr));
    endtask

    task automatic t_fill_copy();
        put(2); put(32'hAABBCC); put(1); put(2); put(3); put(4);
        put(3); put(11); put(12); put(13); put(14); put(15); put(16);
        publish();
        run_pass(1'b1);
        check(k_q.size() == 2, "R7", "op count", 64'(k_q.size()), 64'd2);
        if (k_q.size() == 2) begin
            check(k_q[0] == 2'd1 && a_q[0] == pk(32'hAABBCC, 1, 2, 3, 4, 0), "R7", "fill",
                  {62'd0, k_q[0]}, 64'd1);
            check(k_q[1] == 2'd2 && a_q[1] == pk(11, 12, 13, 14, 15, 16), "R7", "copy",
                  {62'd0, k_q[1]}, 64'd2);
        end
    endtask

    task automatic t_cursor();
        put(19); put(7); put(1); put(2); put(40); put(2); put(8);
        for (int i = 0; i < 24; i++) put(32'hC000 + i);
        put(1); put(9); put(9); put(9); put(9);
        publish();
        run_pass(1'b1);
        check(k_q.size() == 2 && k_q[0] == 2'd3 && a_q[0] == pk(7, 1, 2, 40, 2, 8), "R8",
              "cursor op", 64'(k_q.size()), 64'd2);
        check(p_q.size() == 24, "R8", "payload count", 64'(p_q.size()), 64'd24);
        if (p_q.size() == 24) begin
            for (int i = 0; i < 24; i++) begin
                check(p_q[i] == 32'hC000 + i && pi_q[i] == (i >= 4), "R8", "payload word",
                      {31'd0, pi_q[i], p_q[i]}, {31'd0, 1'(i >= 4), 32'hC000 + i});
            end
        end
        check(k_q.size() == 2 && a_q[1] == pk(9, 9, 9, 9, 0, 0), "R8", "sync after payload",
              64'(k_q.size()), 64'd2);
    endtask

    task automatic t_skip();
        put(13); for (int i = 0; i < 6; i++) put(1);
        put(14); for (int i = 0; i < 7; i++) put(2);
        put(28); for (int i = 0; i < 12; i++) put(3);
        put(1); put(21); put(22); put(23); put(24);
        publish();
        run_pass(1'b1);
        check(k_q.size() == 1 && a_q[0] == pk(21, 22, 23, 24, 0, 0), "R9", "skipped ops",
              64'(k_q.size()), 64'd1);
        check(stop == wptr, "R9", "stop after skips", 64'(stop), 64'(wptr));
    endtask

    task automatic t_glyph();
        put(24); put(12); for (int i = 0; i < 10; i++) put(1);
        put(24); put(3); for (int i = 0; i < 7; i++) put(2);
        put(1); put(31); put(32); put(33); put(34);
        publish();
        run_pass(1'b1);
        check(k_q.size() == 1 && a_q[0] == pk(31, 32, 33, 34, 0, 0), "R10", "glyph skip",
              64'(k_q.size()), 64'd1);
        check(stop == wptr, "R10", "stop after glyph", 64'(stop), 64'(wptr));
    endtask

    task automatic t_end();
        logic [31:0] s0;
        s0 = stop;
        put(0); put(1); put(41); put(42); put(43); put(44);
        publish();
        run_pass(1'b1);
        check(k_q.size() == 0, "R11", "zero opcode no dispatch", 64'(k_q.size()), 64'd0);
        check(stop == s0 + 32'd4 && empty == 1'b0, "R11", "zero opcode consumed",
              64'(stop), 64'(s0 + 32'd4));
        run_pass(1'b1);
        check(k_q.size() == 1 && a_q[0] == pk(41, 42, 43, 44, 0, 0), "R11", "rest kept",
              64'(k_q.size()), 64'd1);
        s0 = stop;
        put(9); put(1); put(1); put(1); put(1); put(1);
        publish();
        run_pass(1'b1);
        check(k_q.size() == 0 && stop == s0 + 32'd4, "R11", "unknown opcode",
              64'(stop), 64'(s0 + 32'd4));
        run_pass(1'b1);
        check(k_q.size() == 1 && stop == wptr, "R11", "drain after unknown",
              64'(stop), 64'(wptr));
    endtask

    task automatic t_wrap();
        cfg(RMIN, RMAX, RMAX - 32'd8);
        wptr = RMAX - 32'd8;
        put(1); put(51); put(52); put(53); put(54);
        publish();
        check(wptr == 32'd28, "R2", "bench wrap", 64'(wptr), 64'd28);
        run_pass(1'b1);
        check(k_q.size() == 1 && a_q[0] == pk(51, 52, 53, 54, 0, 0), "R2", "args across wrap",
              64'(k_q.size()), 64'd1);
        check(stop == 32'd28, "R2", "stop wrapped", 64'(stop), 64'd28);
    endtask

    task automatic t_disable();
        logic [31:0] s0;
        s0 = stop;
        @(negedge clk); enable = 1'b0;
        put(1); put(61); put(62); put(63); put(64);
        publish();
        check(empty == 1'b1, "R1", "disabled empty", 64'(empty), 64'd1);
        @(negedge clk); sync = 1'b1;
        @(negedge clk); sync = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && stop == s0, "R1", "disabled sync ignored", 64'(stop), 64'(s0));
        enable = 1'b1;
        run_pass(1'b1);
        check(k_q.size() == 1 && a_q[0] == pk(61, 62, 63, 64, 0, 0), "R1", "enabled again",
              64'(k_q.size()), 64'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_empty_sync();
        t_update();
        t_fill_copy();
        t_cursor();
        t_skip();
        t_glyph();
        t_end();
        t_disable();
        t_wrap();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule